// File: doc/BRIEF.md
# Power-Up and Protection State Controller

This controller sequences the device-level operating phase of a programmable logic device and holds its two protection bits. After reset it sits in a quiet phase with every user path shut and the pin pull-ups on. When the supply-good input rises, it runs a fixed-length register initialization phase. It then enters either the erased phase or user operation, depending on the programmed flag. A drop of the supply-good input at any time sends it back to the quiet phase.

The controller produces the enables for the pin pull-ups, output drivers, input and clock paths, the function blocks and the test port. It also accepts single-cycle command strobes for read-back, program, erase, setting the read lock, setting the write lock and clearing the write lock. It grants or refuses each one according to the lock bits and the current phase. The flash array itself lies outside this block. The grant pulses tell that array what it may do.

Top module: `pwr_sec_ctrl`

## Requirements
- R1: While `supply_ok` is low, and in the cycle after it falls, the controller is quiet. In that phase `pullup_en`=1 and `out_en`, `in_en`, `fb_en`, `tap_en` are all 0.
- R2: After `supply_ok` is seen high in the quiet phase, the initialization phase lasts exactly INIT_CYCLES clock cycles with quiet-phase gating. `init_done` pulses high for one cycle in the first operating cycle.
- R3: In the erased phase (operating with `is_programmed`=0), `tap_en`=1 and `pullup_en`=1, while `out_en`, `in_en` and `fb_en` are 0.
- R4: In user operation (operating with `is_programmed`=1) and with no programming session, `pullup_en`=0 and `out_en`, `in_en`, `fb_en`, `tap_en` are all 1. The phase follows `is_programmed` on every clock while operating.
- R5: In user operation with `isp_active`=1, `out_en`=0 and `pullup_en`=1, while inputs, function blocks and the test port stay enabled.
- R6: A set read lock (`sec_rd`=1) refuses read and program. Erase is still allowed, and a granted erase is the only command that clears `sec_rd`.
- R7: A set write lock (`sec_wr`=1) refuses program and erase. It is cleared only by the clear-write-lock command.
- R8: With both locks set, read, program and erase are all refused.
- R9: A refused request raises `req_err` for exactly one cycle and leaves `sec_rd`, `sec_wr` and the phase unchanged. Requests are refused when the test port is disabled, when more than one strobe is high in a cycle, or when a lock forbids them.
- R10: Each granted read, program or erase produces a one-cycle pulse on its grant output in the cycle after the strobe. The lock commands update `sec_rd`/`sec_wr` in that same next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears phase and lock bits |
| supply_ok | input | 1 | Supply at a safe level |
| is_programmed | input | 1 | 1 when a user pattern is stored, 0 when erased |
| isp_active | input | 1 | Programming session in progress |
| req_read | input | 1 | Read-back request strobe |
| req_prog | input | 1 | Program request strobe |
| req_erase | input | 1 | Full erase request strobe |
| req_lock_rd | input | 1 | Set read lock strobe |
| req_lock_wr | input | 1 | Set write lock strobe |
| req_unlock_wr | input | 1 | Clear write lock strobe |
| pullup_en | output | 1 | Pin pull-up enable |
| out_en | output | 1 | User output driver enable |
| in_en | output | 1 | Input and clock path enable |
| fb_en | output | 1 | Function block enable |
| tap_en | output | 1 | Test port enable |
| init_done | output | 1 | One-cycle pulse at end of initialization |
| rd_grant | output | 1 | Read-back granted |
| prog_grant | output | 1 | Program granted |
| erase_grant | output | 1 | Erase granted |
| req_err | output | 1 | Request refused |
| sec_rd | output | 1 | Read lock bit |
| sec_wr | output | 1 | Write lock bit |

## Verification
A wrong phase shows on the gating outputs in the very next cycle. One example is an initialization counter off by one, which moves the `init_done` pulse and the rise of `tap_en` by a cycle. A wrong lock bit shows up in the lock outputs at once. It also turns the next request's grant into an error, or an error into a grant, one cycle after the strobe. The bench compares every output against a behavioural model on every clock, so any such slip is reported in the cycle it first appears.

// File: rtl/pwr_sec_ctrl.sv
module pwr_sec_ctrl #(
  parameter int INIT_CYCLES = 16,
  localparam int CW = $clog2(INIT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic is_programmed,
  input  logic isp_active,
  input  logic req_read,
  input  logic req_prog,
  input  logic req_erase,
  input  logic req_lock_rd,
  input  logic req_lock_wr,
  input  logic req_unlock_wr,
  output logic pullup_en,
  output logic out_en,
  output logic in_en,
  output logic fb_en,
  output logic tap_en,
  output logic init_done,
  output logic rd_grant,
  output logic prog_grant,
  output logic erase_grant,
  output logic req_err,
  output logic sec_rd,
  output logic sec_wr
);

  typedef enum logic [1:0] {PH_QUIET, PH_INIT, PH_ERASED, PH_USER} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [5:0]    reqs;
  logic          live, multi, deny;

  assign reqs  = {req_read, req_prog, req_erase, req_lock_rd, req_lock_wr, req_unlock_wr};
  assign live  = supply_ok && (phase == PH_ERASED || phase == PH_USER);
  assign multi = (reqs & (reqs - 6'd1)) != 6'd0;
  assign deny  = !live || multi
              || (req_read  && sec_rd)
              || (req_prog  && (sec_rd || sec_wr))
              || (req_erase && sec_wr);

  assign tap_en    = (phase == PH_ERASED) || (phase == PH_USER);
  assign in_en     = (phase == PH_USER);
  assign fb_en     = (phase == PH_USER);
  assign out_en    = (phase == PH_USER) && !isp_active;
  assign pullup_en = !out_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_QUIET;
      cnt <= '0;
      init_done <= 1'b0;
      rd_grant <= 1'b0;
      prog_grant <= 1'b0;
      erase_grant <= 1'b0;
      req_err <= 1'b0;
      sec_rd <= 1'b0;
      sec_wr <= 1'b0;
    end else begin
      init_done <= 1'b0;
      rd_grant <= 1'b0;
      prog_grant <= 1'b0;
      erase_grant <= 1'b0;
      req_err <= 1'b0;
      if (!supply_ok) begin
        phase <= PH_QUIET;
      end else begin
        case (phase)
          PH_QUIET: begin
            phase <= PH_INIT;
            cnt <= '0;
          end
          PH_INIT: begin
            if (cnt == CW'(INIT_CYCLES - 1)) begin
              phase <= is_programmed ? PH_USER : PH_ERASED;
              init_done <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: phase <= is_programmed ? PH_USER : PH_ERASED;
        endcase
      end
      if (reqs != 6'd0) begin
        if (deny) begin
          req_err <= 1'b1;
        end else begin
          rd_grant <= req_read;
          prog_grant <= req_prog;
          if (req_erase) begin
            erase_grant <= 1'b1;
            sec_rd <= 1'b0;
          end
          if (req_lock_rd) sec_rd <= 1'b1;
          if (req_lock_wr) sec_wr <= 1'b1;
          if (req_unlock_wr) sec_wr <= 1'b0;
        end
      end
    end
  end

  AST_QUIET_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!tap_en && !out_en && !fb_en && pullup_en)); // R1
  AST_DONE_OPERATING: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> tap_en); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> !init_done); // R2
  AST_ISP_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    isp_active |-> !out_en); // R5
  AST_RDLOCK_CLEAR_BY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_rd) |-> erase_grant); // R6
  AST_READ_NEEDS_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |-> !$past(sec_rd)); // R6
  AST_PROG_NEEDS_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    prog_grant |-> (!$past(sec_rd) && !$past(sec_wr))); // R7
  AST_ERASE_NEEDS_WR_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    erase_grant |-> !$past(sec_wr)); // R8
  AST_REFUSE_KEEPS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> ($stable(sec_rd) && $stable(sec_wr))); // R9
  AST_GRANT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_grant, prog_grant, erase_grant, req_err})); // R10

endmodule

// File: tb/test_pwr_sec_ctrl.sv
module test_pwr_sec_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_INIT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, is_programmed = 1'b0, isp_active = 1'b0;
  logic req_read = 1'b0, req_prog = 1'b0, req_erase = 1'b0;
  logic req_lock_rd = 1'b0, req_lock_wr = 1'b0, req_unlock_wr = 1'b0;
  logic pullup_en, out_en, in_en, fb_en, tap_en, init_done;
  logic rd_grant, prog_grant, erase_grant, req_err, sec_rd, sec_wr;

  pwr_sec_ctrl #(.INIT_CYCLES(N_INIT)) i_pwr_sec_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;

  // model: phase 0 quiet, 1 init, 2 erased, 3 user
  int m_ph = 0, m_cnt = 0;
  bit m_done, m_rg, m_pg, m_eg, m_err, m_srd, m_swr;

  always @(posedge clk) begin
    int n;
    bit ok_port, refuse;
    cycles++;
    m_done = 0; m_rg = 0; m_pg = 0; m_eg = 0; m_err = 0;
    if (!rst_n) begin
      m_ph = 0; m_srd = 0; m_swr = 0;
    end else begin
      n = req_read + req_prog + req_erase + req_lock_rd + req_lock_wr + req_unlock_wr;
      ok_port = supply_ok && m_ph >= 2;
      if (n > 0) begin
        refuse = !ok_port || n > 1;
        if (req_read && m_srd) refuse = 1;
        if (req_prog && (m_srd || m_swr)) refuse = 1;
        if (req_erase && m_swr) refuse = 1;
        if (refuse) m_err = 1;
        else if (req_read) m_rg = 1;
        else if (req_prog) m_pg = 1;
        else if (req_erase) begin m_eg = 1; m_srd = 0; end
        else if (req_lock_rd) m_srd = 1;
        else if (req_lock_wr) m_swr = 1;
        else m_swr = 0;
      end
      if (!supply_ok) m_ph = 0;
      else if (m_ph == 0) begin m_ph = 1; m_cnt = 1; end
      else if (m_ph == 1) begin
        if (m_cnt == N_INIT) begin m_ph = is_programmed ? 3 : 2; m_done = 1; end
        else m_cnt++;
      end else m_ph = is_programmed ? 3 : 2;
    end
  end

  task automatic chk(string name, string req, logic act, bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, name, act, exp, cycles);
    end
  endtask

  function automatic string gate_tag();
    if (m_ph < 2) return "R1";
    if (m_ph == 2) return "R3";
    if (isp_active) return "R5";
    return "R4";
  endfunction

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    chk("tap_en", gate_tag(), tap_en, m_ph >= 2);
    chk("in_en", gate_tag(), in_en, m_ph == 3);
    chk("fb_en", gate_tag(), fb_en, m_ph == 3);
    chk("out_en", gate_tag(), out_en, m_ph == 3 && !isp_active);
    chk("pullup_en", gate_tag(), pullup_en, !(m_ph == 3 && !isp_active));
    chk("init_done", "R2", init_done, m_done);
    chk("rd_grant", "R6", rd_grant, m_rg);     // R10 pulse timing
    chk("prog_grant", "R7", prog_grant, m_pg); // R10
    chk("erase_grant", "R8", erase_grant, m_eg);
    chk("req_err", "R9", req_err, m_err);
    chk("sec_rd", "R6", sec_rd, m_srd);
    chk("sec_wr", "R7", sec_wr, m_swr);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit rd, bit pg, bit er, bit lr, bit lw, bit uw);
    @(negedge clk);
    req_read = rd; req_prog = pg; req_erase = er;
    req_lock_rd = lr; req_lock_wr = lw; req_unlock_wr = uw;
    @(negedge clk);
    {req_read, req_prog, req_erase, req_lock_rd, req_lock_wr, req_unlock_wr} = '0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);                          // R1 quiet while supply low
    pulse(1, 0, 0, 0, 0, 0);          // R9 refused while quiet
    supply_ok = 1'b1;
    idle(N_INIT + 4);                 // R2 init, then R3 erased
    pulse(1, 0, 0, 0, 0, 0);          // read ok
    pulse(0, 0, 0, 1, 0, 0);          // R6 set read lock
    pulse(1, 0, 0, 0, 0, 0);          // refused
    pulse(0, 1, 0, 0, 0, 0);          // refused
    pulse(0, 0, 1, 0, 0, 0);          // R6 erase clears read lock
    pulse(0, 1, 0, 0, 0, 0);          // program ok
    pulse(0, 0, 0, 0, 1, 0);          // R7 set write lock
    pulse(0, 0, 1, 0, 0, 0);          // refused
    pulse(0, 1, 0, 0, 0, 0);          // refused
    pulse(1, 0, 0, 0, 0, 0);          // read still ok
    pulse(0, 0, 0, 1, 0, 0);          // R8 both locks
    pulse(1, 0, 0, 0, 0, 0);
    pulse(0, 1, 0, 0, 0, 0);
    pulse(0, 0, 1, 0, 0, 0);
    pulse(0, 0, 0, 0, 0, 1);          // R7 clear write lock
    pulse(0, 0, 1, 0, 0, 0);          // erase clears read lock
    pulse(1, 1, 0, 0, 0, 0);          // R9 two strobes refused
    is_programmed = 1'b1;
    idle(3);                          // R4 user
    isp_active = 1'b1;
    idle(3);                          // R5
    pulse(0, 1, 0, 0, 0, 0);
    isp_active = 1'b0;
    idle(2);
    is_programmed = 1'b0;
    idle(2);
    is_programmed = 1'b1;
    supply_ok = 1'b0;
    idle(3);                          // R1 drop
    pulse(0, 0, 1, 0, 0, 0);
    supply_ok = 1'b1;
    idle(N_INIT + 4);                 // R2 again into user
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    tests++;
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule